// File: doc/BRIEF.md
# Programmable Ramp PWM Sequencer

This block drives one PWM output whose duty value is moved over time by a small stored program, not held in a fixed compare register. A free-running 8-bit counter advances once per base tick. The output is high while the ramp value is at or above the counter. A 64-entry program of 16-bit instruction words changes the ramp value. An instruction can jump it to a rail, walk it one unit at a time at a programmed pace, load it outright, or send execution back to the first word.

The host fills the program store through a single byte-wide port, one word as two bytes. It then sets the run bit to start the engine at word 0. Clearing the run bit freezes the engine and the ramp value at once. The base tick is derived from the clock by a divider (`CLK_PER_TICK`; the default gives about 32.768 kHz from 200 MHz). Every step can optionally be slowed by a second divider (`PRE_DIV`, default 512).

Top module: `rpwm_seq`

## Requirements
- R1: While `rst` is high, `ramp_val` is 0x00, `pwm_out` is low and the run bit is clear.
- R2: The 8-bit counter advances once per base tick, where a base tick is every `CLK_PER_TICK` clocks, and wraps from 0xFF to 0x00. The registered `pwm_out` is high for exactly (ramp+1)·`CLK_PER_TICK` clocks out of every 256·`CLK_PER_TICK` while the ramp is constant, and is always high at ramp 0xFF.
- R3: Each program word is written with two `prog_we` strobes on `prog_byte`: bits 15:8 first, then bits 7:0. The write pointer moves to the next word only after the low byte.
- R4: Word 0x0000, or a word never written since reset, sends execution back to word 0 without changing the ramp.
- R5: A step word (bit 15 = 0) with step time bits 13:8 equal to zero jumps the ramp at once: to 0xFF when bit 7 is 0, and to 0x00 when bit 7 is 1. So 0x007F gives maximum and 0x00FF gives minimum.
- R6: A step word with a non-zero step time moves the ramp by one unit per step, upward when bit 7 is 0 and downward when it is 1. It takes bits 6:0 steps, and successive steps are exactly (bits 13:8) tick periods apart. A count of 0 does nothing.
- R7: Bit 14 of a step word paces its steps on a slow tick, which occurs every `PRE_DIV` base ticks, in place of the base tick.
- R8: A word with bits 15:13 = 3'b101 branches back to word 0.
- R9: A word with bits 15:13 = 3'b110 loads bits 7:0 into the ramp in one instruction.
- R10: Steps that would go past 0xFF or below 0x00 are absorbed. The ramp stays at the rail and does not wrap.
- R11: A `ctl_we` strobe latches `ctl_run`. While the run bit is clear, the ramp does not change. When the bit rises, execution restarts at word 0 and the program write pointer returns to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program byte write strobe |
| prog_byte | input | 8 | Program byte, high half of a word first |
| ctl_we | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit value latched on `ctl_we` |
| pwm_out | output | 1 | Registered PWM output |
| ramp_val | output | 8 | Current ramp (duty) value |

## Verification
The assertions watch properties that hold on every cycle:
- the counter steps by one on each base tick and holds otherwise;
- the output is high after a cycle at ramp 0xFF;
- the ramp is frozen while the run bit is clear;
- execution is at word 0 after a rising run bit;
- the write pointer moves only on the low byte.

Instruction semantics can only be shown by the bench scenarios. These cover the order of ramp values each program produces, step spacing in clocks, slow-tick pacing, rail saturation, looping by branch and by the start word, and measured duty.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;
  localparam int RAMP_W = 8;
  localparam int WORD_W = 16;
  localparam logic [2:0] OP_BRANCH = 3'b101;
  localparam logic [2:0] OP_LOAD   = 3'b110;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_STEP} eng_st_t;
endpackage

// File: rtl/rpwm_tick.sv
module rpwm_tick #(
  parameter int CLK_PER_TICK = 6104,
  parameter int PRE_DIV      = 512
) (
  input  logic clk,
  input  logic rst,
  output logic base_tick,
  output logic slow_tick
);
  localparam int DW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [DW-1:0] div_q;

  assign base_tick = (div_q == DW'(CLK_PER_TICK - 1));

  always_ff @(posedge clk) begin
    if (rst)            div_q <= '0;
    else if (base_tick) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      assign slow_tick = base_tick && (pre_q == PW'(PRE_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)            pre_q <= '0;
        else if (slow_tick) pre_q <= '0;
        else if (base_tick) pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign slow_tick = base_tick;
    end
  endgenerate
endmodule

// File: rtl/rpwm_progmem.sv
module rpwm_progmem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          ptr_clr,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_word,
  output logic          rd_valid,
  output logic [AW-1:0] wptr_o,
  output logic          lo_phase_o
);
  logic [15:0]      mem [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [7:0]       hi_q;
  logic             lo_q;
  logic [AW-1:0]    wptr_q;
  logic             commit;

  assign commit     = wr_en && lo_q && !ptr_clr;
  assign wptr_o     = wptr_q;
  assign lo_phase_o = lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      lo_q   <= 1'b0;
      hi_q   <= '0;
    end else if (ptr_clr) begin
      wptr_q <= '0;
      lo_q   <= 1'b0;
    end else if (wr_en) begin
      if (!lo_q) begin
        hi_q <= wr_data;
        lo_q <= 1'b1;
      end else begin
        lo_q   <= 1'b0;
        wptr_q <= wptr_q + 1'b1;
      end
    end
  end

  // RAM-style array: write port plus registered read port
  always_ff @(posedge clk) begin
    if (commit) mem[wptr_q] <= {hi_q, wr_data};
    rd_word <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (commit) valid_q[wptr_q] <= 1'b1;
      rd_valid <= valid_q[rd_addr];
    end
  end
endmodule

// File: rtl/rpwm_engine.sv
module rpwm_engine
  import rpwm_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              base_tick,
  input  logic              slow_tick,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              rd_valid,
  output logic [AW-1:0]     pc_o,
  output logic [RAMP_W-1:0] ramp_o
);
  eng_st_t           st_q;
  logic [AW-1:0]     pc_q;
  logic [RAMP_W-1:0] ramp_q, ramp_nx;
  logic              dir_q, pre_q;
  logic [5:0]        stime_q, tcnt_q;
  logic [6:0]        left_q;
  logic              step_tick;

  logic [2:0] w_op;
  logic       w_pre, w_dir;
  logic [5:0] w_stime;
  logic [6:0] w_count;

  assign w_op    = rd_word[15:13];
  assign w_pre   = rd_word[14];
  assign w_stime = rd_word[13:8];
  assign w_dir   = rd_word[7];
  assign w_count = rd_word[6:0];

  assign step_tick = pre_q ? slow_tick : base_tick;
  assign pc_o      = pc_q;
  assign ramp_o    = ramp_q;

  // saturating unit step
  always_comb begin
    if (dir_q) ramp_nx = (ramp_q == '0) ? '0 : ramp_q - 1'b1;
    else       ramp_nx = (ramp_q == '1) ? '1 : ramp_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pc_q    <= '0;
      ramp_q  <= '0;
      dir_q   <= 1'b0;
      pre_q   <= 1'b0;
      stime_q <= '0;
      tcnt_q  <= '0;
      left_q  <= '0;
    end else if (!run) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          pc_q <= '0;
          st_q <= ST_FETCH;
        end
        ST_FETCH: st_q <= ST_EXEC;
        ST_EXEC: begin
          st_q <= ST_FETCH;
          if (!rd_valid || rd_word == '0 || w_op == OP_BRANCH) begin
            pc_q <= '0;
          end else if (w_op == OP_LOAD) begin
            ramp_q <= rd_word[7:0];
            pc_q   <= pc_q + 1'b1;
          end else if (!rd_word[15]) begin
            if (w_stime == '0) begin
              ramp_q <= w_dir ? '0 : '1;
              pc_q   <= pc_q + 1'b1;
            end else if (w_count == '0) begin
              pc_q <= pc_q + 1'b1;
            end else begin
              dir_q   <= w_dir;
              pre_q   <= w_pre;
              stime_q <= w_stime;
              left_q  <= w_count;
              tcnt_q  <= '0;
              st_q    <= ST_STEP;
            end
          end else begin
            pc_q <= pc_q + 1'b1;
          end
        end
        ST_STEP: begin
          if (step_tick) begin
            if (tcnt_q == stime_q - 6'd1) begin
              tcnt_q <= '0;
              ramp_q <= ramp_nx;
              if (left_q == 7'd1) begin
                pc_q <= pc_q + 1'b1;
                st_q <= ST_FETCH;
              end else begin
                left_q <= left_q - 1'b1;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rpwm_cmp.sv
module rpwm_cmp
  import rpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic [RAMP_W-1:0] ramp,
  output logic [RAMP_W-1:0] cnt_o,
  output logic              pwm_o
);
  logic [RAMP_W-1:0] cnt_q;

  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pwm_o <= 1'b0;
    end else begin
      if (base_tick) cnt_q <= cnt_q + 1'b1;
      pwm_o <= (ramp >= cnt_q);
    end
  end
endmodule

// File: rtl/rpwm_seq.sv
module rpwm_seq
  import rpwm_pkg::*;
#(
  parameter int CLK_PER_TICK = 6104,
  parameter int PRE_DIV      = 512,
  parameter int DEPTH        = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       prog_we,
  input  logic [7:0] prog_byte,
  input  logic       ctl_we,
  input  logic       ctl_run,
  output logic       pwm_out,
  output logic [7:0] ramp_val
);
  localparam int AW = $clog2(DEPTH);

  logic              run_q, ptr_clr;
  logic              base_tick, slow_tick;
  logic [WORD_W-1:0] rd_word;
  logic              rd_valid;
  logic [AW-1:0]     pc, wptr;
  logic              lo_phase;
  logic [RAMP_W-1:0] pwm_cnt;

  assign ptr_clr = ctl_we && ctl_run && !run_q;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= 1'b0;
    else if (ctl_we) run_q <= ctl_run;
  end

  rpwm_tick #(.CLK_PER_TICK(CLK_PER_TICK), .PRE_DIV(PRE_DIV)) u_tick (
    .clk(clk), .rst(rst), .base_tick(base_tick), .slow_tick(slow_tick)
  );

  rpwm_progmem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .wr_en(prog_we), .wr_data(prog_byte),
    .ptr_clr(ptr_clr), .rd_addr(pc), .rd_word(rd_word),
    .rd_valid(rd_valid), .wptr_o(wptr), .lo_phase_o(lo_phase)
  );

  rpwm_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst(rst), .run(run_q), .base_tick(base_tick),
    .slow_tick(slow_tick), .rd_word(rd_word), .rd_valid(rd_valid),
    .pc_o(pc), .ramp_o(ramp_val)
  );

  rpwm_cmp u_cmp (
    .clk(clk), .rst(rst), .base_tick(base_tick), .ramp(ramp_val),
    .cnt_o(pwm_cnt), .pwm_o(pwm_out)
  );
endmodule

// File: rtl/rpwm_seq_chk.sv
module rpwm_seq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          run_q,
  input logic [7:0]    ramp_val,
  input logic          pwm_out,
  input logic          base_tick,
  input logic [7:0]    pwm_cnt,
  input logic [AW-1:0] pc,
  input logic          prog_we,
  input logic          lo_phase,
  input logic [AW-1:0] wptr,
  input logic          ptr_clr
);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> (pwm_cnt == $past(pwm_cnt) + 8'd1));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !base_tick |=> $stable(pwm_cnt));

  p_full_high_r2: assert property (@(posedge clk) disable iff (rst)
    (ramp_val == 8'hFF) |=> pwm_out);

  p_halt_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> $stable(ramp_val));

  p_restart_zero_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |=> (pc == '0));

  p_ptr_low_r3: assert property (@(posedge clk) disable iff (rst)
    (prog_we && lo_phase && !ptr_clr) |=> (wptr == $past(wptr) + 1'b1));

  p_ptr_high_r3: assert property (@(posedge clk) disable iff (rst)
    (prog_we && !lo_phase && !ptr_clr) |=> ($stable(wptr) && lo_phase));
endmodule

bind rpwm_seq rpwm_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .run_q(run_q), .ramp_val(ramp_val),
  .pwm_out(pwm_out), .base_tick(base_tick), .pwm_cnt(pwm_cnt), .pc(pc),
  .prog_we(prog_we), .lo_phase(lo_phase), .wptr(wptr), .ptr_clr(ptr_clr)
);

// File: tb/rpwm_seq_tb.sv
`timescale 1ns/1ps
module rpwm_seq_tb;
  localparam int TB_DIV = 4;
  localparam int TB_PRE = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_we = 1'b0;
  logic [7:0] prog_byte = '0;
  logic       ctl_we = 1'b0;
  logic       ctl_run = 1'b0;
  logic       pwm_out;
  logic [7:0] ramp_val;

  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic        checking = 1'b0;
  logic [7:0]  prev = '0;
  logic [7:0]  exp_q[$];
  logic [15:0] prog[$];
  int          chg_t[$];
  string       cur_req = "R1";
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  rpwm_seq #(.CLK_PER_TICK(TB_DIV), .PRE_DIV(TB_PRE), .DEPTH(64)) u_dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_byte(prog_byte),
    .ctl_we(ctl_we), .ctl_run(ctl_run), .pwm_out(pwm_out), .ramp_val(ramp_val)
  );

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected ramp values as the design changes ramp_val
  always @(negedge clk) begin
    cyc++;
    if (checking && ramp_val != prev) begin
      chg_t.push_back(cyc);
      if (exp_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL %s unexpected ramp change: actual 0x%0h expected no change",
                 cur_req, ramp_val);
      end else begin
        chk(cur_req, int'(ramp_val), int'(exp_q.pop_front()), "ramp sequence");
      end
    end
    prev = ramp_val;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic set_run(logic b);
    @(negedge clk);
    ctl_we  = 1'b1;
    ctl_run = b;
    @(negedge clk);
    ctl_we  = 1'b0;
  endtask

  task automatic write_word(logic [15:0] w);
    @(negedge clk);
    prog_we   = 1'b1;
    prog_byte = w[15:8];
    @(negedge clk);
    prog_byte = w[7:0];
    @(negedge clk);
    prog_we   = 1'b0;
  endtask

  task automatic drain(int lim);
    int k = 0;
    while (exp_q.size() != 0 && k < lim) begin
      @(negedge clk);
      k++;
    end
    chk(cur_req, exp_q.size(), 0, "pending expected ramp values");
    exp_q.delete();
  endtask

  // driver: load program, push expectations, run until drained
  task automatic go(int extra);
    foreach (prog[i]) write_word(prog[i]);
    chg_t.delete();
    checking = 1'b1;
    set_run(1'b1);
    drain(3000);
    repeat (extra) @(negedge clk);
    checking = 1'b0;
  endtask

  task automatic measure(string req, int exp_high);
    int h = 0;
    repeat (256 * TB_DIV) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
    chk(req, h, exp_high, "high clocks per PWM period");
  endtask

  initial begin
    logic [7:0] frozen;
    repeat (4) @(negedge clk);
    chk("R1", int'(ramp_val), 0, "ramp in reset");
    chk("R1", int'(pwm_out), 0, "pwm_out in reset");
    @(negedge clk);
    rst = 1'b0;
    repeat (50) @(negedge clk);
    chk("R11", int'(ramp_val), 0, "ramp while not running");

    // R9 load + R4 unwritten word loops; R3 bytes assembled high then low
    cur_req = "R3/R9";
    prog = '{16'hC030};
    exp_q = '{8'h30};
    go(200);
    measure("R2", (8'h30 + 1) * TB_DIV);
    set_run(1'b0);

    // R5 jump to maximum, then saturated hold
    cur_req = "R5";
    prog = '{16'h007F, 16'h7F7F};
    exp_q = '{8'hFF};
    go(100);
    measure("R2", 256 * TB_DIV);
    set_run(1'b0);

    // R5 minimum then R6 up 3 steps, step time 2
    cur_req = "R5/R6";
    prog = '{16'h00FF, 16'h0203, 16'h7F7F};
    exp_q = '{8'h00, 8'h01, 8'h02, 8'h03};
    go(50);
    set_run(1'b0);
    chk("R6", chg_t[2] - chg_t[1], 2 * TB_DIV, "step spacing");
    chk("R6", chg_t[3] - chg_t[2], 2 * TB_DIV, "step spacing");

    // R10 upward saturation: 10 steps from 0xFC stop at 0xFF
    cur_req = "R10";
    prog = '{16'hC0FC, 16'h010A, 16'h7F7F};
    exp_q = '{8'hFC, 8'hFD, 8'hFE, 8'hFF};
    go(150);
    set_run(1'b0);

    // R10/R6 downward from 0x03 by 5 stops at 0x00
    cur_req = "R10/R6";
    prog = '{16'hC003, 16'h0185, 16'h7FFF};
    exp_q = '{8'h03, 8'h02, 8'h01, 8'h00};
    go(100);
    set_run(1'b0);

    // R7 slow-tick pacing
    cur_req = "R7";
    prog = '{16'hC010, 16'h4102, 16'h7FFF};
    exp_q = '{8'h10, 8'h11, 8'h12};
    go(0);
    set_run(1'b0);
    chk("R7", chg_t[2] - chg_t[1], TB_PRE * TB_DIV, "slow step spacing");

    // R8 branch loop
    cur_req = "R8";
    prog = '{16'h00FF, 16'h0102, 16'hA000};
    exp_q = '{8'h00, 8'h01, 8'h02, 8'h00, 8'h01, 8'h02};
    go(0);
    set_run(1'b0);

    // R4 go-to-start word loop
    cur_req = "R4";
    prog = '{16'hC050, 16'h0101, 16'h0000};
    exp_q = '{8'h50, 8'h51, 8'h50, 8'h51};
    go(0);
    set_run(1'b0);

    // R11 halt mid-ramp, then restart at word 0
    cur_req = "R11/R6";
    prog = '{16'hC020, 16'h0A7F};
    exp_q = '{8'h20, 8'h21, 8'h22};
    go(0);
    set_run(1'b0);
    chk("R6", chg_t[2] - chg_t[1], 10 * TB_DIV, "step spacing");
    frozen = ramp_val;
    repeat (300) @(negedge clk);
    chk("R11", int'(ramp_val), int'(frozen), "ramp frozen while halted");
    chk("R11", int'(ramp_val), 8'h22, "value at halt");
    cur_req = "R11";
    prog.delete();
    exp_q = '{8'h20, 8'h21};
    go(0);
    set_run(1'b0);

    repeat (10) @(negedge clk);
    summary();
  end
endmodule